// File: doc/BRIEF.md
# Byte-Masked Pipelined SRAM Datapath

This block is a synchronous single-port word memory. It has one shared data bus, which is modelled as three signals: an input, an output and a drive enable. The enable controls an external tri-state buffer. Each word is split into lanes of nine bits: eight data bits and one check bit. The default configuration has four lanes, which makes a 36-bit word.

A write command carries a lane mask. The write data follows on the bus in the next cycle, called the data phase. Only the lanes named in the mask are merged into the stored word. A read-modify-write of one byte therefore becomes a single masked write.

Reads are pipelined. The addressed word reaches the output register two clock edges after the command edge. It stays there until the next read completes. The bus driver is enabled only when the active-low output enable is asserted and the cycle is not a write data phase.

Top module: `bytemask_sram`

## Requirements
- R1: While `rst_n` is low, `bus_out` is all zeros. After reset it stays zero until the first read completes.
- R2: A write command is sampled with `cmd_en`=1 and `cmd_we`=1 on edge E. For every lane k whose bit `lane_sel[k]` was set at E, bits [9k+8:9k] of the addressed word become the `bus_in` value sampled on edge E+1.
- R3: Lanes whose `lane_sel` bit was 0 at the command edge keep their previous contents. A write with an all-zero mask changes nothing.
- R4: The lane mask is taken anew with every command. When two writes are issued back to back, each one uses only its own mask, address and data phase.
- R5: A read command is sampled with `cmd_en`=1 and `cmd_we`=0 on edge E. The addressed word appears on `bus_out` after edge E+2, not earlier. `bus_out` holds its value in every cycle in which no read completes.
- R6: `bus_oe` is 0 throughout the cycle that follows a write command edge (the data phase), whatever `out_en_n` is.
- R7: While `out_en_n` is 1, `bus_oe` is 0.
- R8: When `out_en_n` is 0 and the current cycle is not a write data phase, `bus_oe` is 1.
- R9: With `cmd_en`=0 no access takes place: the memory contents and `bus_out` are unchanged, whatever `cmd_we`, `addr`, `lane_sel` and `bus_in` are.
- R10: A read issued in the cycle right after a write to the same address returns the merged word that the write produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| cmd_en | input | 1 | Command valid for this edge |
| cmd_we | input | 1 | 1 selects write, 0 selects read |
| addr | input | ADDR_W | Word address of the command |
| lane_sel | input | LANES | Per-lane write mask, bit k covers bits [9k+8:9k] |
| out_en_n | input | 1 | Active-low output enable |
| bus_in | input | LANES*LANE_W | Data seen on the bus, sampled in the write data phase |
| bus_out | output | LANES*LANE_W | Read data register driven toward the bus |
| bus_oe | output | 1 | Tri-state drive enable for `bus_out` |

## Verification
The assertions assume that `rst_n` is held low for at least one falling clock edge. They also assume that every input changes only away from the rising edge. Given those assumptions, the checker's own registered copy of the command stream lines up with the design's pipeline.

The bench changes all inputs on falling edges. It keeps reset asserted for several cycles, and it only ever puts one command on each edge. That single-command rule is the protocol the assertions rely on. The random stimulus mixes reads, masked writes, idle cycles and random `out_en_n` inside that protocol. It always drives write data exactly one cycle after the command that it belongs to.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;

   function automatic sram_op_e decode_op(input logic en, input logic we);
      if (!en)     return OP_IDLE;
      else if (we) return OP_WRITE;
      else         return OP_READ;
   endfunction

endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_en,
   input  logic                 cmd_we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [LANES-1:0]     lane_sel,
   output sram_pkg::sram_op_e   op_q,
   output logic [ADDR_W-1:0]    addr_q,
   output logic [LANES-1:0]     sel_q
);
   import sram_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         sel_q  <= '0;
      end else begin
         op_q <= decode_op(cmd_en, cmd_we);
         if (cmd_en) begin
            addr_q <= addr;
            sel_q  <= cmd_we ? lane_sel : '0;
         end
      end
   end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int ADDR_W = 4,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [LANES-1:0]          wr_sel,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   output logic [LANES*LANE_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic              lane_we;

      assign lane_we = wr_en & wr_sel[g];

      always_ff @(posedge clk) begin
         if (lane_we)
            store[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (rd_en)
            rd_data[g*LANE_W +: LANE_W] <= store[acc_addr];
      end
   end

endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] out_q
);
   logic arr_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_vld <= 1'b0;
         out_q   <= '0;
      end else begin
         arr_vld <= rd_issue;
         if (arr_vld)
            out_q <= arr_data;
      end
   end

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl (
   input  logic out_en_n,
   input  logic wr_phase,
   output logic drive_en
);
   always_comb drive_en = !out_en_n && !wr_phase;
endmodule

// File: rtl/bytemask_sram.sv
module bytemask_sram #(
   parameter int ADDR_W = 4,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_en,
   input  logic                      cmd_we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES-1:0]          lane_sel,
   input  logic                      out_en_n,
   input  logic [LANES*LANE_W-1:0]   bus_in,
   output logic [LANES*LANE_W-1:0]   bus_out,
   output logic                      bus_oe
);
   import sram_pkg::*;

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("bytemask_sram: ADDR_W out of range");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("bytemask_sram: LANE_W must hold data plus check bit");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("bytemask_sram: LANES must be at least 1");
   end

   sram_op_e            op_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [LANES-1:0]    sel_q;
   logic [DATA_W-1:0]   arr_data;
   logic                wr_phase;
   logic                rd_issue;

   sram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_en   (cmd_en),
      .cmd_we   (cmd_we),
      .addr     (addr),
      .lane_sel (lane_sel),
      .op_q     (op_q),
      .addr_q   (addr_q),
      .sel_q    (sel_q)
   );

   assign wr_phase = (op_q == OP_WRITE);
   assign rd_issue = (op_q == OP_READ);

   sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk      (clk),
      .wr_en    (wr_phase),
      .rd_en    (rd_issue),
      .acc_addr (addr_q),
      .wr_sel   (sel_q),
      .wr_data  (bus_in),
      .rd_data  (arr_data)
   );

   sram_read_pipe #(.DATA_W(DATA_W)) u_rdp (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_issue (rd_issue),
      .arr_data (arr_data),
      .out_q    (bus_out)
   );

   sram_bus_ctl u_bus (
      .out_en_n (out_en_n),
      .wr_phase (wr_phase),
      .drive_en (bus_oe)
   );

endmodule

// File: rtl/bytemask_sram_chk.sv
module bytemask_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_en,
   input logic              cmd_we,
   input logic              out_en_n,
   input logic              bus_oe,
   input logic [DATA_W-1:0] bus_out
);
   logic wr_seen;
   logic rd_s1;
   logic rd_s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen <= 1'b0;
         rd_s1   <= 1'b0;
         rd_s2   <= 1'b0;
      end else begin
         wr_seen <= cmd_en && cmd_we;
         rd_s1   <= cmd_en && !cmd_we;
         rd_s2   <= rd_s1;
      end
   end

   always @(negedge clk) begin
      if (!rst_n)
         p_reset_zero_r1: assert (bus_out == '0);
   end

   p_oe_off_wphase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |-> !bus_oe);

   p_oe_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !bus_oe);

   p_oe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en_n && !wr_seen) |-> bus_oe);

   p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_s2 |=> $stable(bus_out));

endmodule

bind bytemask_sram bytemask_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_en   (cmd_en),
   .cmd_we   (cmd_we),
   .out_en_n (out_en_n),
   .bus_oe   (bus_oe),
   .bus_out  (bus_out)
);

// File: tb/bytemask_sram_tb.sv
module bytemask_sram_tb;
   localparam int AW = 4;
   localparam int LW = 9;
   localparam int NL = 4;
   localparam int DW = LW * NL;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_en, cmd_we;
   logic [AW-1:0] addr;
   logic [NL-1:0] lane_sel;
   logic          out_en_n;
   logic [DW-1:0] bus_in;
   logic [DW-1:0] bus_out;
   logic          bus_oe;

   always #2 clk = ~clk;

   bytemask_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_we(cmd_we),
      .addr(addr), .lane_sel(lane_sel), .out_en_n(out_en_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] last_out;

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [NL-1:0] sel);
      logic [DW-1:0] r = old_w;
      for (int k = 0; k < NL; k++)
         if (sel[k]) r[k*LW +: LW] = new_w[k*LW +: LW];
      return r;
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] t = {$urandom(), $urandom()};
      return t[DW-1:0];
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      cmd_en = 1'b0; cmd_we = 1'b0; lane_sel = '0;
   endtask

   // write: command at N0, data phase N0..N1, check oe in data phase (R6) and after (R7/R8)
   task automatic do_write(input logic [AW-1:0] a, input logic [NL-1:0] s,
                           input logic [DW-1:0] d, input logic oen);
      @(negedge clk);
      cmd_en = 1'b1; cmd_we = 1'b1; addr = a; lane_sel = s; out_en_n = oen;
      @(negedge clk);
      idle_in(); bus_in = d; out_en_n = oen;
      #1 check("R6 oe off in write data phase", {35'd0, bus_oe}, '0);
      model[a] = merge(model[a], d, s);
      @(negedge clk);
      bus_in = rnd_word();
      #1 check(oen ? "R7 oe gated by out_en_n" : "R8 oe on when enabled",
               {35'd0, bus_oe}, {35'd0, !oen});
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      @(negedge clk);
      cmd_en = 1'b1; cmd_we = 1'b0; addr = a; lane_sel = NL'($urandom());
      out_en_n = 1'b0;
      @(negedge clk);
      idle_in();
      @(negedge clk);
      check("R5 output not early", bus_out, last_out);
      @(negedge clk);
      check("R5 read data at second edge", bus_out, model[a]);
      last_out = model[a];
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; idle_in(); addr = '0; out_en_n = 1'b1; bus_in = '0;
      last_out = '0;
      repeat (3) @(negedge clk);
      check("R1 reset output zero", bus_out, '0);
      check("R7 oe off while out_en_n high", {35'd0, bus_oe}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 output zero after reset", bus_out, '0);

      for (int a = 0; a < DEPTH; a++) begin
         model[a] = '0;
         do_write(AW'(a), '1, rnd_word(), 1'b0);
      end
      for (int a = 0; a < DEPTH; a++) do_read(AW'(a));

      // R2/R3 partial masks
      do_write(4'd3, 4'b0101, rnd_word(), 1'b0);
      do_read(4'd3);
      do_write(4'd3, 4'b1000, rnd_word(), 1'b1);
      do_read(4'd3);
      do_write(4'd7, 4'b0000, rnd_word(), 1'b0);   // R3 empty mask
      do_read(4'd7);

      // R4 back-to-back writes with different masks
      begin
         logic [DW-1:0] d1 = rnd_word();
         logic [DW-1:0] d2 = rnd_word();
         @(negedge clk);
         cmd_en = 1; cmd_we = 1; addr = 4'd5; lane_sel = 4'b0011; out_en_n = 0;
         @(negedge clk);
         cmd_en = 1; cmd_we = 1; addr = 4'd5; lane_sel = 4'b1100; bus_in = d1;
         #1 check("R6 oe off first data phase", {35'd0, bus_oe}, '0);
         @(negedge clk);
         idle_in(); bus_in = d2;
         #1 check("R6 oe off second data phase", {35'd0, bus_oe}, '0);
         model[5] = merge(merge(model[5], d1, 4'b0011), d2, 4'b1100);
         @(negedge clk);
         bus_in = rnd_word();
         do_read(4'd5);   // R4
      end

      // R10 read right after write, same address
      begin
         logic [DW-1:0] d = rnd_word();
         @(negedge clk);
         cmd_en = 1; cmd_we = 1; addr = 4'd9; lane_sel = 4'b0110; out_en_n = 0;
         @(negedge clk);
         cmd_en = 1; cmd_we = 0; addr = 4'd9; bus_in = d;
         model[9] = merge(model[9], d, 4'b0110);
         @(negedge clk);
         idle_in(); bus_in = rnd_word();
         @(negedge clk);
         @(negedge clk);
         check("R10 read after write merged", bus_out, model[9]);
         last_out = model[9];
      end

      // R9 cmd_en low ignores everything
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         cmd_en = 0; cmd_we = 1'($urandom()); addr = AW'($urandom());
         lane_sel = NL'($urandom()); bus_in = rnd_word(); out_en_n = 1'($urandom());
         #1 check("R9 output unchanged when idle", bus_out, last_out);
      end
      for (int a = 0; a < DEPTH; a++) do_read(AW'(a));   // R9 memory intact

      // random mix
      for (int i = 0; i < 400; i++) begin
         int kind = int'($urandom_range(0, 2));
         if (kind == 0) do_read(AW'($urandom()));
         else if (kind == 1)
            do_write(AW'($urandom()), NL'($urandom()), rnd_word(), 1'($urandom()));
         else begin
            @(negedge clk);
            idle_in(); out_en_n = 1'($urandom()); bus_in = rnd_word();
            #1 check("R7 R8 idle oe", {35'd0, bus_oe}, {35'd0, !out_en_n});
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule